// File: doc/BRIEF.md
# TileLink Error Flag Translator

This block sits on the TileLink side of a cache and translates error indications between the wire format and the form the cache keeps internally. Inbound on the C channel, a single corrupt bit arrives alongside the message opcode; the block splits it into a separate denied flag and corrupt flag according to whether the opcode is a dataless or a data-carrying acknowledge. From those two flags it also derives the tag-error and data-error bits that the cache writes into the line's metadata.

Outbound on the D channel, the block combines the ECC check results of the read with the error bits stored in the line's metadata. It produces the denied and corrupt bits of the response, and a denied response always carries corrupt as well. The ECC computation, the directory and all flow control decisions belong to the surrounding logic.

Each direction is a valid/ready stream with an opaque payload that passes through untouched. A beat transfers on a clock edge where valid and ready are both high. A sender holds valid and all its fields steady until the transfer. With the output register enabled (`OUT_REG`=1, the default), each stream has one register slot and the input is ready whenever that slot is empty or the downstream side is taking the held beat. With `OUT_REG`=0, both streams are purely combinational and ready passes straight upstream.

Top module: `tl_err_xlate`

## Requirements
- R1: The C-side corrupt output is 1 exactly when the input corrupt bit is 1 and the opcode is 5 or 7 (the acknowledges that carry data).
- R2: The C-side denied output is 1 exactly when the input corrupt bit is 1 and the opcode is 4 or 6 (the acknowledges without data).
- R3: For C opcodes 0 to 3 both decoded flags are 0, whatever the value of the corrupt bit.
- R4: The metadata tag-error output equals the decoded denied flag, and the metadata data-error output equals the decoded corrupt flag of the same beat.
- R5: The D-side denied output is 1 exactly when the ECC tag check failed or the stored tag-error bit is set.
- R6: The D-side corrupt output is 1 when denied is 1, when the ECC data check failed, or when the stored data-error bit is set, and is 0 otherwise.
- R7: Payloads leave each stream unchanged and in the order they were accepted, with no beat lost or duplicated.
- R8: With `OUT_REG`=1, an output beat that is valid and not taken keeps valid and all its fields unchanged on the next cycle. The input ready equals the negation of output valid, ORed with output ready.
- R9: After reset, both output valids are 0 and both input readies are 1.
- R10: With `OUT_REG`=1, a beat accepted on one edge is offered on the output from the next cycle on, never in the same cycle. With an always-ready sink, it is taken exactly one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_in_valid | input | 1 | Inbound C beat valid |
| c_in_ready | output | 1 | Inbound C beat accepted |
| c_in_opcode | input | 3 | C channel opcode |
| c_in_corrupt | input | 1 | C channel raw corrupt bit |
| c_in_payload | input | PAY_W | Opaque C payload |
| c_out_valid | output | 1 | Decoded C beat valid |
| c_out_ready | input | 1 | Decoded C beat taken |
| c_out_denied | output | 1 | Decoded denied flag |
| c_out_corrupt | output | 1 | Decoded corrupt flag |
| c_out_meta_tag_err | output | 1 | Tag-error bit to store in metadata |
| c_out_meta_data_err | output | 1 | Data-error bit to store in metadata |
| c_out_payload | output | PAY_W | C payload passed through |
| d_in_valid | input | 1 | Outbound D request valid |
| d_in_ready | output | 1 | Outbound D request accepted |
| d_in_ecc_tag_err | input | 1 | ECC tag check failed on read |
| d_in_ecc_data_err | input | 1 | ECC data check failed on read |
| d_in_meta_tag_err | input | 1 | Stored tag-error bit |
| d_in_meta_data_err | input | 1 | Stored data-error bit |
| d_in_payload | input | PAY_W | Opaque D payload |
| d_out_valid | output | 1 | D beat valid |
| d_out_ready | input | 1 | D beat taken |
| d_out_denied | output | 1 | D denied bit |
| d_out_corrupt | output | 1 | D corrupt bit |
| d_out_payload | output | PAY_W | D payload passed through |

## Verification
The checker runs on every cycle. It checks that the two decoded C flags are never both set, that the metadata bits track the decoded flags, and that a denied D beat is also corrupt. It also checks that a stalled registered beat holds steady, that ready follows the slot occupancy, and that nothing is valid straight after reset. The exact opcode decode, the mapping of all sixteen D-side input combinations, payload ordering across random back-pressure and the one-edge latency are checked only by the bench's reference model, which tracks every accepted beat through a queue.

// File: rtl/tlerr_pkg.sv
package tlerr_pkg;
  // C channel acknowledge opcodes; decoding depends on these values
  localparam logic [2:0] OPC_SNP_ACK      = 3'd4;
  localparam logic [2:0] OPC_SNP_ACK_DATA = 3'd5;
  localparam logic [2:0] OPC_EVICT        = 3'd6;
  localparam logic [2:0] OPC_EVICT_DATA   = 3'd7;

  typedef struct packed {
    logic denied;
    logic corrupt;
  } err_pair_t;

  typedef struct packed {
    logic tag_err;
    logic data_err;
  } meta_err_t;
endpackage

// File: rtl/tlerr_c_decode.sv
module tlerr_c_decode
  import tlerr_pkg::*;
(
  input  logic [2:0] opcode,
  input  logic       raw_corrupt,
  output err_pair_t  flags
);
  logic is_dataless_ack;
  logic is_data_ack;

  always_comb begin
    is_dataless_ack = (opcode == OPC_SNP_ACK) || (opcode == OPC_EVICT);
    is_data_ack     = (opcode == OPC_SNP_ACK_DATA) || (opcode == OPC_EVICT_DATA);
    flags.denied    = raw_corrupt && is_dataless_ack;
    flags.corrupt   = raw_corrupt && is_data_ack;
  end
endmodule

// File: rtl/tlerr_meta_gen.sv
module tlerr_meta_gen
  import tlerr_pkg::*;
(
  input  err_pair_t flags,
  output meta_err_t meta
);
  always_comb begin
    meta.tag_err  = flags.denied;
    meta.data_err = flags.corrupt;
  end
endmodule

// File: rtl/tlerr_d_encode.sv
module tlerr_d_encode
  import tlerr_pkg::*;
(
  input  logic      ecc_tag_err,
  input  logic      ecc_data_err,
  input  meta_err_t stored,
  output err_pair_t flags
);
  always_comb begin
    flags.denied  = ecc_tag_err || stored.tag_err;
    // a denied response is always marked corrupt as well
    flags.corrupt = flags.denied || ecc_data_err || stored.data_err;
  end
endmodule

// File: rtl/tlerr_stage.sv
module tlerr_stage #(
  parameter int DW  = 8,
  parameter bit REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  generate
    if (REG) begin : g_reg
      logic          vld_q;
      logic [DW-1:0] dat_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= in_data;
        end
      end
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/tl_err_xlate.sv
module tl_err_xlate
  import tlerr_pkg::*;
#(
  parameter int PAY_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             c_in_valid,
  output logic             c_in_ready,
  input  logic [2:0]       c_in_opcode,
  input  logic             c_in_corrupt,
  input  logic [PAY_W-1:0] c_in_payload,
  output logic             c_out_valid,
  input  logic             c_out_ready,
  output logic             c_out_denied,
  output logic             c_out_corrupt,
  output logic             c_out_meta_tag_err,
  output logic             c_out_meta_data_err,
  output logic [PAY_W-1:0] c_out_payload,
  input  logic             d_in_valid,
  output logic             d_in_ready,
  input  logic             d_in_ecc_tag_err,
  input  logic             d_in_ecc_data_err,
  input  logic             d_in_meta_tag_err,
  input  logic             d_in_meta_data_err,
  input  logic [PAY_W-1:0] d_in_payload,
  output logic             d_out_valid,
  input  logic             d_out_ready,
  output logic             d_out_denied,
  output logic             d_out_corrupt,
  output logic [PAY_W-1:0] d_out_payload
);
  localparam int C_DW = PAY_W + $bits(err_pair_t) + $bits(meta_err_t);
  localparam int D_DW = PAY_W + $bits(err_pair_t);

  // C direction: split corrupt by opcode, then derive metadata bits
  err_pair_t c_flags;
  meta_err_t c_meta;

  tlerr_c_decode u_c_dec (
    .opcode      (c_in_opcode),
    .raw_corrupt (c_in_corrupt),
    .flags       (c_flags)
  );

  tlerr_meta_gen u_meta (
    .flags (c_flags),
    .meta  (c_meta)
  );

  logic [C_DW-1:0] c_pack_in, c_pack_out;
  assign c_pack_in = {c_in_payload, c_flags, c_meta};

  tlerr_stage #(.DW(C_DW), .REG(OUT_REG)) u_c_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (c_in_valid),
    .in_ready  (c_in_ready),
    .in_data   (c_pack_in),
    .out_valid (c_out_valid),
    .out_ready (c_out_ready),
    .out_data  (c_pack_out)
  );

  assign {c_out_payload, c_out_denied, c_out_corrupt,
          c_out_meta_tag_err, c_out_meta_data_err} = c_pack_out;

  // D direction: merge check results and stored bits
  err_pair_t d_flags;
  meta_err_t d_stored;
  assign d_stored = '{tag_err: d_in_meta_tag_err, data_err: d_in_meta_data_err};

  tlerr_d_encode u_d_enc (
    .ecc_tag_err  (d_in_ecc_tag_err),
    .ecc_data_err (d_in_ecc_data_err),
    .stored       (d_stored),
    .flags        (d_flags)
  );

  logic [D_DW-1:0] d_pack_in, d_pack_out;
  assign d_pack_in = {d_in_payload, d_flags};

  tlerr_stage #(.DW(D_DW), .REG(OUT_REG)) u_d_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (d_in_valid),
    .in_ready  (d_in_ready),
    .in_data   (d_pack_in),
    .out_valid (d_out_valid),
    .out_ready (d_out_ready),
    .out_data  (d_pack_out)
  );

  assign {d_out_payload, d_out_denied, d_out_corrupt} = d_pack_out;
endmodule

// File: rtl/tl_err_xlate_chk.sv
module tl_err_xlate_chk #(
  parameter int PAY_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             c_in_ready,
  input logic             c_out_valid,
  input logic             c_out_ready,
  input logic             c_out_denied,
  input logic             c_out_corrupt,
  input logic             c_out_meta_tag_err,
  input logic             c_out_meta_data_err,
  input logic [PAY_W-1:0] c_out_payload,
  input logic             d_in_ready,
  input logic             d_out_valid,
  input logic             d_out_ready,
  input logic             d_out_denied,
  input logic             d_out_corrupt,
  input logic [PAY_W-1:0] d_out_payload
);
  assert_c_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    c_out_valid |-> !(c_out_denied && c_out_corrupt));

  assert_meta_follows_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_out_valid |-> (c_out_meta_tag_err == c_out_denied) &&
                    (c_out_meta_data_err == c_out_corrupt));

  assert_denied_implies_corrupt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_out_valid && d_out_denied) |-> d_out_corrupt);

  generate
    if (OUT_REG) begin : g_reg_chk
      assert_c_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_out_valid && !c_out_ready) |=> c_out_valid && $stable(c_out_payload) &&
          $stable(c_out_denied) && $stable(c_out_corrupt));

      assert_d_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_out_valid && !d_out_ready) |=> d_out_valid && $stable(d_out_payload) &&
          $stable(d_out_denied) && $stable(d_out_corrupt));

      assert_ready_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_in_ready == (!c_out_valid || c_out_ready)) &&
        (d_in_ready == (!d_out_valid || d_out_ready)));

      assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> !c_out_valid && !d_out_valid);
    end
  endgenerate
endmodule

bind tl_err_xlate tl_err_xlate_chk #(.PAY_W(PAY_W), .OUT_REG(OUT_REG)) chk_i (
  .clk                 (clk),
  .rst_n               (rst_n),
  .c_in_ready          (c_in_ready),
  .c_out_valid         (c_out_valid),
  .c_out_ready         (c_out_ready),
  .c_out_denied        (c_out_denied),
  .c_out_corrupt       (c_out_corrupt),
  .c_out_meta_tag_err  (c_out_meta_tag_err),
  .c_out_meta_data_err (c_out_meta_data_err),
  .c_out_payload       (c_out_payload),
  .d_in_ready          (d_in_ready),
  .d_out_valid         (d_out_valid),
  .d_out_ready         (d_out_ready),
  .d_out_denied        (d_out_denied),
  .d_out_corrupt       (d_out_corrupt),
  .d_out_payload       (d_out_payload)
);

// File: tb/tl_err_xlate_tb_top.sv
module tl_err_xlate_tb_top;
  localparam int PAY_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             c_in_valid = 0, c_in_ready, c_in_corrupt = 0;
  logic [2:0]       c_in_opcode = 0;
  logic [PAY_W-1:0] c_in_payload = 0;
  logic             c_out_valid, c_out_ready = 0, c_out_denied, c_out_corrupt;
  logic             c_out_meta_tag_err, c_out_meta_data_err;
  logic [PAY_W-1:0] c_out_payload;
  logic             d_in_valid = 0, d_in_ready;
  logic             d_ecc_t = 0, d_ecc_d = 0, d_met_t = 0, d_met_d = 0;
  logic [PAY_W-1:0] d_in_payload = 0;
  logic             d_out_valid, d_out_ready = 0, d_out_denied, d_out_corrupt;
  logic [PAY_W-1:0] d_out_payload;

  tl_err_xlate #(.PAY_W(PAY_W), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .c_in_valid(c_in_valid), .c_in_ready(c_in_ready), .c_in_opcode(c_in_opcode),
    .c_in_corrupt(c_in_corrupt), .c_in_payload(c_in_payload),
    .c_out_valid(c_out_valid), .c_out_ready(c_out_ready),
    .c_out_denied(c_out_denied), .c_out_corrupt(c_out_corrupt),
    .c_out_meta_tag_err(c_out_meta_tag_err), .c_out_meta_data_err(c_out_meta_data_err),
    .c_out_payload(c_out_payload),
    .d_in_valid(d_in_valid), .d_in_ready(d_in_ready),
    .d_in_ecc_tag_err(d_ecc_t), .d_in_ecc_data_err(d_ecc_d),
    .d_in_meta_tag_err(d_met_t), .d_in_meta_data_err(d_met_d),
    .d_in_payload(d_in_payload),
    .d_out_valid(d_out_valid), .d_out_ready(d_out_ready),
    .d_out_denied(d_out_denied), .d_out_corrupt(d_out_corrupt),
    .d_out_payload(d_out_payload)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit directed = 1'b1;
  bit finished = 1'b0;

  // expected beats: {payload, denied, corrupt}
  logic [PAY_W+1:0] c_q[$];
  logic [PAY_W+1:0] d_q[$];
  int               c_tq[$];
  int               d_tq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference: decode rules from the requirements
  function automatic logic [1:0] c_ref(input logic [2:0] op, input logic cor);
    logic den, crp;
    den = cor && (op == 3'd4 || op == 3'd6);   // R2
    crp = cor && (op == 3'd5 || op == 3'd7);   // R1, R3 for 0..3
    return {den, crp};
  endfunction

  function automatic logic [1:0] d_ref(input logic et, ed, mt, md);
    logic den;
    den = et || mt;                            // R5
    return {den, den || ed || md};             // R6
  endfunction

  // one cycle: sample the handshakes that the coming edge will perform
  task automatic step(input bit keep_c, input bit keep_d);
    bit cf, df, cof, dof;
    logic [PAY_W+1:0] e;
    int t;
    #1;
    cf  = c_in_valid && c_in_ready;
    df  = d_in_valid && d_in_ready;
    cof = c_out_valid && c_out_ready;
    dof = d_out_valid && d_out_ready;
    if (cof) begin
      if (c_q.size() == 0) chk(0, "R7 c spurious beat", c_out_payload, 0);
      else begin
        e = c_q.pop_front(); t = c_tq.pop_front();
        chk(c_out_payload == e[PAY_W+1:2], "R7 c payload", c_out_payload, e[PAY_W+1:2]);
        chk(c_out_denied == e[1], "R2 c denied", c_out_denied, e[1]);
        chk(c_out_corrupt == e[0], "R1 R3 c corrupt", c_out_corrupt, e[0]);
        chk({c_out_meta_tag_err, c_out_meta_data_err} == e[1:0], "R4 meta bits",
            {c_out_meta_tag_err, c_out_meta_data_err}, e[1:0]);
        if (directed) chk(cyc == t + 1, "R10 c latency", cyc, t + 1);
        else          chk(cyc > t, "R10 c not same cycle", cyc, t + 1);
      end
    end
    if (dof) begin
      if (d_q.size() == 0) chk(0, "R7 d spurious beat", d_out_payload, 0);
      else begin
        e = d_q.pop_front(); t = d_tq.pop_front();
        chk(d_out_payload == e[PAY_W+1:2], "R7 d payload", d_out_payload, e[PAY_W+1:2]);
        chk(d_out_denied == e[1], "R5 d denied", d_out_denied, e[1]);
        chk(d_out_corrupt == e[0], "R6 d corrupt", d_out_corrupt, e[0]);
        if (directed) chk(cyc == t + 1, "R10 d latency", cyc, t + 1);
        else          chk(cyc > t, "R10 d not same cycle", cyc, t + 1);
      end
    end
    chk(c_in_ready == (!c_out_valid || c_out_ready), "R8 c ready rule", c_in_ready,
        !c_out_valid || c_out_ready);
    if (cf) begin
      c_q.push_back({c_in_payload, c_ref(c_in_opcode, c_in_corrupt)}); c_tq.push_back(cyc);
    end
    if (df) begin
      d_q.push_back({d_in_payload, d_ref(d_ecc_t, d_ecc_d, d_met_t, d_met_d)}); d_tq.push_back(cyc);
    end
    @(negedge clk);
    cyc++;
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!c_out_valid && !d_out_valid, "R9 valids after reset", {c_out_valid, d_out_valid}, 0);
    chk(c_in_ready && d_in_ready, "R9 readies after reset", {c_in_ready, d_in_ready}, 3);
    @(negedge clk);

    // directed: every opcode/corrupt pair and every D input combination
    c_out_ready = 1; d_out_ready = 1;
    for (int i = 0; i < 16; i++) begin
      c_in_valid = 1; c_in_opcode = i[2:0]; c_in_corrupt = i[3]; c_in_payload = PAY_W'(i + 8'h40);
      d_in_valid = 1; {d_ecc_t, d_ecc_d, d_met_t, d_met_d} = i[3:0]; d_in_payload = PAY_W'(i + 8'h80);
      step(0, 0);
    end
    c_in_valid = 0; d_in_valid = 0;
    step(0, 0); step(0, 0);

    // random traffic with back-pressure on both sides
    directed = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      if (!(c_in_valid && !c_in_ready)) begin
        c_in_valid = $urandom_range(0, 1); c_in_opcode = 3'($urandom);
        c_in_corrupt = $urandom_range(0, 1); c_in_payload = PAY_W'($urandom);
      end
      if (!(d_in_valid && !d_in_ready)) begin
        d_in_valid = $urandom_range(0, 1); {d_ecc_t, d_ecc_d, d_met_t, d_met_d} = 4'($urandom);
        d_in_payload = PAY_W'($urandom);
      end
      c_out_ready = ($urandom_range(0, 3) != 0);
      d_out_ready = ($urandom_range(0, 2) != 0);
      step(0, 0);
    end
    // drain
    while (c_in_valid && !c_in_ready || d_in_valid && !d_in_ready) begin
      c_out_ready = 1; d_out_ready = 1; step(0, 0);
    end
    c_in_valid = 0; d_in_valid = 0; c_out_ready = 1; d_out_ready = 1;
    repeat (4) step(0, 0);
    chk(c_q.size() == 0, "R7 c beats all delivered", c_q.size(), 0);
    chk(d_q.size() == 0, "R7 d beats all delivered", d_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule